// File: doc/BRIEF.md
# Flash write-status polling controller

This block sits on the host side of a parallel flash device. It accepts one request at a time: either a byte program or an erase of one or more consecutive sectors. It writes the matching command to the device and then reads the device's status byte until it can decide how the operation ended. Four status bits drive the decision. Bit 7 is data polling and holds the complement of the written bit while busy. Bit 6 flips on every status read while busy. Bit 5 flags an internal failure. Bit 3 reports whether the erase window is closed. The requester gets a one-cycle response carrying done, failure, timeout or rejected, together with the number of sector commands handed to the device.

For a multi-sector erase, the controller first confirms that the device accepted the first sector command. It then adds the remaining sectors one at a time. Before each additional sector command it reads bit 3, and it reads bit 3 again after the command. A closed window before the command stops further sectors. A closed window after the command marks that command as possibly dropped. In both cases the erase still runs to its end and is reported as rejected. When a failure is confirmed, or when the poll watchdog expires, the controller writes a reset command to the device before it responds.

States and transitions: `S_IDLE` goes to `S_CMD` on a request. `S_CMD` goes to `S_ACC_RD` (erase) or `S_POLL_RD` (program). The acceptance loop `S_ACC_RD`/`S_ACC_EV` leaves to `S_PRE_RD` when sectors remain and to `S_POLL_RD` otherwise. `S_PRE_RD`/`S_PRE_EV` leads to `S_ADD_WR` when the window is open and to `S_POLL_RD` when it is shut. `S_ADD_WR` goes to `S_POST_RD`. `S_POST_RD`/`S_POST_EV` goes back to `S_PRE_RD` or on to `S_POLL_RD`. The completion loop `S_POLL_RD`/`S_POLL_EV` ends in `S_RESP` on success or in `S_RST_WR` on failure. Watchdog expiry in any read or evaluate state leads to `S_RST_WR`. `S_RST_WR` goes to `S_RESP`, and `S_RESP` returns to `S_IDLE`.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, and neither bus_wr nor bus_rd is asserted until a request arrives.
- R2: A program request (req_erase=0) writes one command with bus_cmd=0 (0 program, 1 first erase sector, 2 additional erase sector, 3 reset) to req_addr with req_data. The controller then reads status until bit 7 equals req_data[7] and two consecutive reads agree on bit 6. It then responds with resp_code 0 (0 done, 1 failed, 2 timeout, 3 rejected) and resp_nsect 1.
- R3: Status reads are bus_rd pulses whose byte appears on bus_rdata in the next cycle. Every read addresses the programmed location. For an erase, every read addresses the first sector's base, which is the upper AW-SECT_W bits of req_addr with zero low bits.
- R4: After the first-sector erase command, no bit 3 decision and no additional sector command happens until a status read shows bit 7 at 0 or bit 6 differing between two consecutive reads.
- R5: Additional sector k (1 to req_nsect-1) is written with bus_cmd=2 to sector base+k. This happens only right after a status read that showed bit 3 at 0.
- R6: If the read after an additional sector command shows bit 3 at 1, no more sectors are added. That command still counts in resp_nsect, and the erase ends with resp_code 3.
- R7: If the read before an additional sector command shows bit 3 at 1, that sector and all later sectors are not written, and the erase ends with resp_code 3.
- R8: Erase completion is bit 7 at 1 with two consecutive reads agreeing on bit 6. When every requested sector was added, this gives resp_code 0 with resp_nsect equal to req_nsect.
- R9: When bit 5 reads 1, status is read once more. If that read still shows bit 5 at 1 and bit 7 is not at its target, a reset command (bus_cmd=3) is written and then resp_code 1 is returned.
- R10: If the re-read after a bit 5 indication shows bit 7 at its target, polling continues and the operation ends with resp_code 0, with no reset command.
- R11: If the operation does not complete within WDOG_CYCLES cycles of its command, a reset command is written and resp_code 2 is returned.
- R12: resp_valid lasts exactly one cycle, req_ready is 0 while an operation is in progress, and bus_rd and bus_wr are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_erase | input | 1 | 1 for sector erase, 0 for byte program |
| req_addr | input | AW | Program address, or any address in the first erase sector |
| req_data | input | 8 | Byte to program |
| req_nsect | input | CW | Number of consecutive sectors to erase |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_code | output | 2 | 0 done, 1 failed, 2 timeout, 3 rejected |
| resp_nsect | output | CW | Sector or program commands handed to the device |
| bus_wr | output | 1 | Command write strobe |
| bus_rd | output | 1 | Status read strobe |
| bus_cmd | output | 2 | Command code for bus_wr |
| bus_addr | output | AW | Address for command or status read |
| bus_wdata | output | 8 | Program data for bus_wr |
| bus_rdata | input | 8 | Status byte, valid the cycle after bus_rd |

## Verification
The hardest case to reach from the ports is bit 3 rising between an additional sector command and the read that follows it. In that case the controller must report a possibly dropped command instead of silently carrying on. The bench device model closes its erase window on the k-th additional command it receives, and it sweeps k over every position for each sector count. A related race is bit 5 reported in the same read window as completion. The model returns exactly one failure-flagged status byte and then array data, which forces the re-read path to decide.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    // Command codes placed on bus_cmd
    typedef enum logic [1:0] {
        CMD_PROG        = 2'd0,
        CMD_ERASE_FIRST = 2'd1,
        CMD_ERASE_ADD   = 2'd2,
        CMD_RESET       = 2'd3
    } fp_cmd_e;

    // Outcome codes placed on resp_code
    typedef enum logic [1:0] {
        RESP_DONE    = 2'd0,
        RESP_FAIL    = 2'd1,
        RESP_TIMEOUT = 2'd2,
        RESP_REJECT  = 2'd3
    } fp_resp_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_ACC_RD,
        S_ACC_EV,
        S_PRE_RD,
        S_PRE_EV,
        S_ADD_WR,
        S_POST_RD,
        S_POST_EV,
        S_POLL_RD,
        S_POLL_EV,
        S_RST_WR,
        S_RESP
    } fp_state_e;

    // Status byte bit positions
    localparam int unsigned SB_POLL   = 7;
    localparam int unsigned SB_TOGGLE = 6;
    localparam int unsigned SB_FAIL   = 5;
    localparam int unsigned SB_WINDOW = 3;

endpackage

// File: rtl/flash_poll_status_eval.sv
module flash_poll_status_eval
    import flash_poll_pkg::*;
(
    input  logic [7:0] stat,
    input  logic       prev_toggle,
    input  logic       prev_ok,
    input  logic       target_bit,
    output logic       at_target,
    output logic       completed,
    output logic       accepted,
    output logic       fail_seen,
    output logic       window_shut
);
    logic toggle_same;

    always_comb begin
        toggle_same = prev_ok && (stat[SB_TOGGLE] == prev_toggle);
        at_target   = (stat[SB_POLL] == target_bit);
        completed   = at_target && toggle_same;
        accepted    = !stat[SB_POLL] || (prev_ok && (stat[SB_TOGGLE] != prev_toggle));
        fail_seen   = stat[SB_FAIL];
        window_shut = stat[SB_WINDOW];
    end
endmodule

// File: rtl/flash_poll_wdog.sv
module flash_poll_wdog #(
    parameter int unsigned LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int unsigned WW = $clog2(LIMIT + 1);

    logic [WW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (run && !expired) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign expired = (count_q >= WW'(LIMIT));
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int unsigned AW          = 16,
    parameter int unsigned SECT_W      = 12,
    parameter int unsigned MAX_SECT    = 8,
    parameter int unsigned WDOG_CYCLES = 1024,
    localparam int unsigned CW         = $clog2(MAX_SECT + 1),
    localparam int unsigned SNW        = AW - SECT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_erase,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic [CW-1:0] req_nsect,
    output logic          resp_valid,
    output logic [1:0]    resp_code,
    output logic [CW-1:0] resp_nsect,
    output logic          bus_wr,
    output logic          bus_rd,
    output logic [1:0]    bus_cmd,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic [7:0]    bus_rdata
);
    fp_state_e state, nxt;

    logic           erase_q;
    logic [7:0]     data_q;
    logic [AW-1:0]  op_addr_q;
    logic [SNW-1:0] sect_base_q;
    logic [CW-1:0]  nsect_q;
    logic [CW-1:0]  sent_q;
    logic           prev6_q;
    logic           prev_ok_q;
    logic           retry_q;
    logic           rej_q;
    fp_resp_e       code_q;

    logic at_target, completed, accepted, fail_seen, window_shut;
    logic wd_expired, wd_run, wd_clear;
    logic more_sectors;
    logic [SNW-1:0] add_sect;

    assign more_sectors = (sent_q < nsect_q);
    assign add_sect     = sect_base_q + SNW'(sent_q);

    flash_poll_status_eval u_eval (
        .stat        (bus_rdata),
        .prev_toggle (prev6_q),
        .prev_ok     (prev_ok_q),
        .target_bit  (erase_q ? 1'b1 : data_q[7]),
        .at_target   (at_target),
        .completed   (completed),
        .accepted    (accepted),
        .fail_seen   (fail_seen),
        .window_shut (window_shut)
    );

    assign wd_clear = (state == S_CMD);
    assign wd_run   = !(state inside {S_IDLE, S_CMD, S_RST_WR, S_RESP});

    flash_poll_wdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wd_clear),
        .run     (wd_run),
        .expired (wd_expired)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid) nxt = S_CMD;
            S_CMD:     nxt = erase_q ? S_ACC_RD : S_POLL_RD;
            S_ACC_RD:  nxt = wd_expired ? S_RST_WR : S_ACC_EV;
            S_ACC_EV: begin
                if (wd_expired)     nxt = S_RST_WR;
                else if (fail_seen) nxt = S_POLL_RD;
                else if (accepted)  nxt = more_sectors ? S_PRE_RD : S_POLL_RD;
                else                nxt = S_ACC_RD;
            end
            S_PRE_RD:  nxt = wd_expired ? S_RST_WR : S_PRE_EV;
            S_PRE_EV: begin
                if (wd_expired)       nxt = S_RST_WR;
                else if (window_shut) nxt = S_POLL_RD;
                else                  nxt = S_ADD_WR;
            end
            S_ADD_WR:  nxt = S_POST_RD;
            S_POST_RD: nxt = wd_expired ? S_RST_WR : S_POST_EV;
            S_POST_EV: begin
                if (wd_expired)                       nxt = S_RST_WR;
                else if (window_shut || !more_sectors) nxt = S_POLL_RD;
                else                                   nxt = S_PRE_RD;
            end
            S_POLL_RD: nxt = wd_expired ? S_RST_WR : S_POLL_EV;
            S_POLL_EV: begin
                if (wd_expired)                              nxt = S_RST_WR;
                else if (completed)                          nxt = S_RESP;
                else if (retry_q && fail_seen && !at_target) nxt = S_RST_WR;
                else                                         nxt = S_POLL_RD;
            end
            S_RST_WR:  nxt = S_RESP;
            S_RESP:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // Operation context and poll history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_q     <= 1'b0;
            data_q      <= '0;
            op_addr_q   <= '0;
            sect_base_q <= '0;
            nsect_q     <= '0;
            sent_q      <= '0;
            prev6_q     <= 1'b0;
            prev_ok_q   <= 1'b0;
            retry_q     <= 1'b0;
            rej_q       <= 1'b0;
            code_q      <= RESP_DONE;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    erase_q     <= req_erase;
                    data_q      <= req_data;
                    sect_base_q <= req_addr[AW-1:SECT_W];
                    op_addr_q   <= req_erase ? {req_addr[AW-1:SECT_W], {SECT_W{1'b0}}} : req_addr;
                    nsect_q     <= req_nsect;
                    rej_q       <= 1'b0;
                    retry_q     <= 1'b0;
                end
                S_CMD: begin
                    sent_q    <= CW'(1);
                    prev_ok_q <= 1'b0;
                end
                S_ADD_WR: sent_q <= sent_q + 1'b1;
                S_ACC_EV, S_PRE_EV, S_POST_EV, S_POLL_EV: begin
                    prev6_q   <= bus_rdata[SB_TOGGLE];
                    prev_ok_q <= 1'b1;
                    if (wd_expired) begin
                        code_q <= RESP_TIMEOUT;
                    end else if (state == S_PRE_EV || state == S_POST_EV) begin
                        if (window_shut && (state == S_POST_EV || more_sectors)) rej_q <= 1'b1;
                    end else if (state == S_POLL_EV) begin
                        if (completed) begin
                            code_q <= rej_q ? RESP_REJECT : RESP_DONE;
                        end else if (fail_seen && !retry_q) begin
                            retry_q <= 1'b1;
                        end else if (retry_q && fail_seen && !at_target) begin
                            code_q <= RESP_FAIL;
                        end else begin
                            retry_q <= 1'b0;
                        end
                    end
                end
                S_ACC_RD, S_PRE_RD, S_POST_RD, S_POLL_RD: begin
                    if (wd_expired) code_q <= RESP_TIMEOUT;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready  = (state == S_IDLE);
        resp_valid = (state == S_RESP);
        resp_code  = code_q;
        resp_nsect = sent_q;
        bus_wr     = 1'b0;
        bus_rd     = 1'b0;
        bus_cmd    = CMD_PROG;
        bus_addr   = op_addr_q;
        bus_wdata  = data_q;
        unique case (state)
            S_CMD: begin
                bus_wr  = 1'b1;
                bus_cmd = erase_q ? CMD_ERASE_FIRST : CMD_PROG;
            end
            S_ADD_WR: begin
                bus_wr   = 1'b1;
                bus_cmd  = CMD_ERASE_ADD;
                bus_addr = {add_sect, {SECT_W{1'b0}}};
            end
            S_RST_WR: begin
                bus_wr  = 1'b1;
                bus_cmd = CMD_RESET;
            end
            S_ACC_RD, S_PRE_RD, S_POST_RD, S_POLL_RD: bus_rd = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/flash_poll_ctrl_sva.sv
module flash_poll_ctrl_sva #(
    parameter int unsigned AW       = 16,
    parameter int unsigned MAX_SECT = 8,
    localparam int unsigned CW      = $clog2(MAX_SECT + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          resp_valid,
    input logic [1:0]    resp_code,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [1:0]    bus_cmd,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_rdata
);
    logic          rd_d, op_ok, rst_seen, last_b3, acc_ok, pv, p6;
    logic [AW-1:0] op_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_d <= 1'b0; op_ok <= 1'b0; rst_seen <= 1'b0; last_b3 <= 1'b1;
            acc_ok <= 1'b0; pv <= 1'b0; p6 <= 1'b0; op_addr <= '0;
        end else begin
            rd_d <= bus_rd;
            if (bus_wr && (bus_cmd == 2'd0 || bus_cmd == 2'd1)) begin
                op_addr  <= bus_addr;
                op_ok    <= 1'b1;
                rst_seen <= 1'b0;
                acc_ok   <= 1'b0;
                pv       <= 1'b0;
                last_b3  <= 1'b1;
            end
            if (bus_wr && bus_cmd == 2'd3) rst_seen <= 1'b1;
            if (rd_d) begin
                last_b3 <= bus_rdata[3];
                pv      <= 1'b1;
                p6      <= bus_rdata[6];
                if (!bus_rdata[7] || (pv && bus_rdata[6] != p6)) acc_ok <= 1'b1;
            end
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_rd && !bus_wr && !resp_valid));

    assert_read_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (op_ok && bus_addr == op_addr));

    assert_accept_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_cmd == 2'd2) |-> acc_ok);

    assert_add_window_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_cmd == 2'd2) |-> !last_b3);

    assert_reset_before_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_code == 2'd1 || resp_code == 2'd2)) |-> rst_seen);

    assert_resp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_rd_wr_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
endmodule

bind flash_poll_ctrl flash_poll_ctrl_sva #(.AW(AW), .MAX_SECT(MAX_SECT)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata)
);

// File: tb/flash_poll_ctrl_tb.sv
module flash_poll_ctrl_tb;
    localparam int AW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_erase = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic [CW-1:0] req_nsect = '0;
    logic          req_ready, resp_valid, bus_wr, bus_rd;
    logic [1:0]    resp_code, bus_cmd;
    logic [CW-1:0] resp_nsect;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic [7:0]    bus_rdata;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    flash_poll_ctrl #(.AW(AW), .SECT_W(12), .MAX_SECT(8), .WDOG_CYCLES(200)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_erase(req_erase), .req_addr(req_addr), .req_data(req_data),
        .req_nsect(req_nsect), .resp_valid(resp_valid), .resp_code(resp_code),
        .resp_nsect(resp_nsect), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Device model configuration (written by tasks only)
    logic          c_erase = 0, c_hang = 0, m_load = 0;
    logic [7:0]    c_data = 0;
    int            c_left = 0, c_fail = 0, c_win = 0, c_rk = 0;
    logic [AW-1:0] c_exp = 0;

    // Device model state (written by the model only)
    logic          m_erase, m_hang, m_busy, m_tog, m_forced, m_rst, closed, f5;
    logic [7:0]    m_data;
    int            m_left, m_fail, m_win, m_rk, m_wcnt, m_adds, m_bad;
    logic [AW-1:0] m_exp;

    assign closed = m_forced || (m_wcnt >= m_win);

    always @(posedge clk) begin
        if (!rst_n) begin
            m_erase <= 0; m_hang <= 0; m_busy <= 0; m_tog <= 0; m_forced <= 0; m_rst <= 0;
            m_data <= 0; m_left <= 0; m_fail <= 0; m_win <= 0; m_rk <= 0; m_wcnt <= 0;
            m_adds <= 0; m_bad <= 0; m_exp <= 0; bus_rdata <= 0;
        end else begin
            if (m_wcnt < 1000000) m_wcnt <= m_wcnt + 1;
            if (m_load) begin
                m_erase <= c_erase; m_hang <= c_hang; m_data <= c_data; m_left <= c_left;
                m_fail <= c_fail; m_win <= c_win; m_rk <= c_rk; m_exp <= c_exp;
                m_busy <= 0; m_tog <= 0; m_forced <= 0; m_rst <= 0; m_adds <= 0; m_bad <= 0;
            end
            if (bus_wr) begin
                case (bus_cmd)
                    2'd0, 2'd1: begin m_busy <= 1; m_wcnt <= 0; end
                    2'd2: begin
                        m_adds <= m_adds + 1;
                        if (m_adds + 1 == m_rk) m_forced <= 1;
                        if (!closed) m_wcnt <= 0;
                    end
                    default: begin m_rst <= 1; m_busy <= 0; end
                endcase
            end
            if (bus_rd) begin
                if (bus_addr != m_exp) m_bad <= m_bad + 1;
                if (!m_busy || (m_left == 0 && m_fail == 0 && !m_hang)) begin
                    bus_rdata <= m_erase ? 8'hFF : m_data;
                    m_busy <= 0;
                end else begin
                    f5 = (m_left == 0);
                    m_tog <= ~m_tog;
                    bus_rdata <= m_erase ? {1'b0, m_tog, f5, 1'b0, closed, 3'b000}
                                         : {~m_data[7], m_tog, f5, 5'b00000};
                    if (m_left == 0 && m_fail == 2) m_fail <= 0;
                    if (m_left != 0 && !m_hang) m_left <= m_left - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input bit er, input logic [AW-1:0] addr, input logic [7:0] d,
                          input int n, input int left, input int fl, input bit hg,
                          input int win, input int rk, input int e_code, input int e_n,
                          input bit e_rst, input string tag);
        bit got = 0;
        int code = 0, nn = 0;
        @(negedge clk);
        c_erase = er; c_data = d; c_left = left; c_fail = fl; c_hang = hg;
        c_win = win; c_rk = rk;
        c_exp = er ? {addr[AW-1:12], 12'h000} : addr;
        m_load = 1;
        @(negedge clk);
        m_load = 0;
        req_valid = 1; req_erase = er; req_addr = addr; req_data = d; req_nsect = CW'(n);
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 0, "R12 busy ready", int'(req_ready), 0);
        for (int i = 0; i < 800 && !got; i++) begin
            @(negedge clk);
            if (resp_valid) begin got = 1; code = resp_code; nn = resp_nsect; end
        end
        chk(got, {tag, " response seen"}, int'(got), 1);
        chk(code == e_code, {tag, " resp_code"}, code, e_code);
        chk(nn == e_n, {tag, " resp_nsect"}, nn, e_n);
        chk(m_rst == e_rst, {tag, " reset command R9 R11"}, int'(m_rst), int'(e_rst));
        chk(m_bad == 0, "R3 status read address", m_bad, 0);
        if (er) chk(m_adds == e_n - 1, {tag, " R4 R5 added sectors"}, m_adds, e_n - 1);
        @(negedge clk);
        chk(resp_valid == 0, "R12 response pulse", int'(resp_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R1 ready after reset", int'(req_ready), 1);
        chk(resp_valid == 0, "R1 no response after reset", int'(resp_valid), 0);
        chk(!bus_rd && !bus_wr, "R1 bus quiet after reset", int'({bus_rd, bus_wr}), 0);

        // R2: every data byte, busy length from the data value
        for (int d = 0; d < 256; d++)
            run_op(0, {8'(d), 8'(d) ^ 8'h5A}, 8'(d), 1, d % 4, 0, 0, 1000000, 0,
                   0, 1, 0, "R2 program");

        // R9 / R10 / R11 on program
        for (int d = 0; d < 256; d += 51) begin
            run_op(0, 16'h1234, 8'(d), 1, 2, 1, 0, 1000000, 0, 1, 1, 1, "R9 program fail");
            run_op(0, 16'h4321, 8'(d), 1, 1, 2, 0, 1000000, 0, 0, 1, 0, "R10 program race");
        end
        run_op(0, 16'h0F0F, 8'h3C, 1, 5, 0, 1, 1000000, 0, 2, 1, 1, "R11 program timeout");

        // Erase sweeps over sector count
        for (int n = 1; n <= 8; n++) begin
            run_op(1, 16'h2ABC, 8'h00, n, 2 * n + 3, 0, 0, 1000000, 0,
                   0, n, 0, "R8 erase all sectors");
            run_op(1, 16'h7123, 8'h00, n, 2 * n + 3, 0, 0, 0, 0,
                   (n > 1) ? 3 : 0, 1, 0, "R7 erase window shut before");
            for (int k = 1; k < n; k++)
                run_op(1, 16'h9FFF, 8'h00, n, 2 * n + 3, 0, 0, 1000000, k,
                       3, 1 + k, 0, "R6 erase window shut after");
        end
        run_op(1, 16'h5000, 8'h00, 2, 7, 1, 0, 1000000, 0, 1, 2, 1, "R9 erase fail");
        run_op(1, 16'h6001, 8'h00, 2, 7, 2, 0, 1000000, 0, 0, 2, 0, "R10 erase race");
        run_op(1, 16'hE123, 8'h00, 3, 5, 0, 1, 1000000, 0, 2, 3, 1, "R11 erase timeout");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule